// File: doc/BRIEF.md
# Command/Response Transfer State Machine

This block runs the byte-level command and response exchange between a host and a command execution engine. The host reaches it through two registers: a status register, and a data port that takes a byte-addressed access of one to four bytes. Command bytes go into a local buffer. The block reads the command's length from a big-endian 32-bit field in the byte stream. While the command is incomplete it keeps an "expecting more" flag set. When the host commits the command, the block sends a one-cycle start strobe and the command length to the engine.

The engine writes its response into the same buffer and then signals completion. The host reads the response back through the data port in byte order, using a burst count in the status register to size its accesses. Five states govern which host writes are honoured: idle, ready, reception, execution and completion. An abort path covers a command that is still arriving and one that is already executing. Only the requester that currently owns the block may access it.

Top module: `cmdrsp_xfer`

## Requirements
- R1: After reset the block is idle. Status flags are clear. A 4-byte status read returns the family code in bits 27:26 and the buffer size as the burst count in bits 23:8.
- R2: A status write with only bit 6 (command-ready) set behaves as follows. In idle it moves to ready, sets flag bit 6 and pulses `irq_ready`. In ready it only rewinds the offset. In reception it aborts to ready with bit 6 set and pulses `irq_ready`. In completion it returns to ready, clears bit 4 (data-available), and sets bit 6 with an `irq_ready` pulse if bit 6 was clear.
- R3: A status write with only bit 5 (go) set is acted on only in reception with bit 3 (expect) clear. It pulses `go_pulse` and, from the next cycle, presents the number of buffered bytes on `cmd_len`. In any other case go is ignored.
- R4: A status write with only bit 1 (retry) set is acted on only in completion. It rewinds the read offset and sets flags bit 7 (valid) and bit 4 (data-available).
- R5: The first data-port write in ready moves the block to reception and sets bits 3 and 7. Data writes in idle, execution or completion are dropped.
- R6: Once more than 5 bytes are held, the command length is taken from bytes 2..5 (byte 2 most significant). Bit 3 stays set while the length exceeds the bytes held and clears when the command is complete. A write that finds the buffer full clears bit 3 and stores nothing.
- R7: Engine completion during execution sets flags to valid plus data-available, enters completion, rewinds the offset and pulses `irq_valid`. If `eng_selftest` is high at that moment, bit 2 (self-test done) is set.
- R8: A data-port read returns 0xFF per byte outside completion or without data-available. In completion it returns response bytes in order. The read that takes the last byte, counted by the response's own length field, clears bit 4 and pulses `irq_valid`.
- R9: The burst count is the number of response bytes left while data-available is set, and the free buffer space otherwise. For a 1-byte status access it saturates at 255.
- R10: Bit 2 (self-test done) and the family code survive every status update until reset.
- R11: A data access is handled least significant byte first. It is clipped so that it does not pass the end of the 32-bit word addressed by `byte_off`.
- R12: With `owner` low, reads return all ones and writes change nothing.
- R13: Command-ready written during execution pulses `cancel_pulse`. When the engine then completes, the block enters ready with bit 6 set and pulses `irq_ready` instead of presenting the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owner | input | 1 | Access comes from the owning requester |
| wr_en | input | 1 | Host write (has priority over rd_en) |
| rd_en | input | 1 | Host read |
| reg_sel | input | 1 | 0 = status register, 1 = data port |
| byte_off | input | 2 | Byte offset of the access within the word |
| acc_size | input | 3 | Access size in bytes, 1 to 4 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| go_pulse | output | 1 | Start strobe to the engine |
| cmd_len | output | CW | Length of the committed command |
| cancel_pulse | output | 1 | Cancel request to the engine |
| eng_we | input | 1 | Engine writes a response byte |
| eng_addr | input | AW | Response byte address |
| eng_wdata | input | 8 | Response byte |
| eng_done | input | 1 | Engine finished |
| eng_selftest | input | 1 | Self-test completed, sampled with eng_done |
| irq_ready | output | 1 | Command-ready event |
| irq_valid | output | 1 | Status-valid event |

## Verification
The command is sent as whole words, then as a word clipped by a nonzero offset, then as single bytes. This separates correct byte-order handling from correct clipping, and shows whether expect clears on exactly the byte that completes the length. The response is read with full words, a clipped word and reads past the end, which separates the burst count of the readback from the free-space count. A second pass through retry shows whether the offset really rewinds. Aborts are tried in reception and in execution, and a command that claims more bytes than the buffer holds shows the buffer-full rule. Go, retry and command-ready are each written in states where they must be ignored, and the bench confirms through the status register that nothing changed.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        XS_IDLE  = 3'd0,
        XS_READY = 3'd1,
        XS_RECV  = 3'd2,
        XS_EXEC  = 3'd3,
        XS_DONE  = 3'd4
    } xfer_state_e;

    // status flag bit positions (software visible)
    localparam int B_VALID  = 7;
    localparam int B_CRDY   = 6;
    localparam int B_GO     = 5;
    localparam int B_DAVAIL = 4;
    localparam int B_EXPECT = 3;
    localparam int B_STDONE = 2;
    localparam int B_RETRY  = 1;

    localparam logic [7:0] F_VALID  = 8'h80;
    localparam logic [7:0] F_CRDY   = 8'h40;
    localparam logic [7:0] F_DAVAIL = 8'h10;
    localparam logic [7:0] F_EXPECT = 8'h08;
    localparam logic [7:0] F_STDONE = 8'h04;

    // replace the flags, keeping only the sticky self-test bit
    function automatic logic [7:0] sts_keep(input logic [7:0] cur, input logic [7:0] flags);
        return (cur & F_STDONE) | flags;
    endfunction

endpackage

// File: rtl/xfer_len_parse.sv
module xfer_len_parse #(
    parameter int unsigned BUF_BYTES = 256,
    parameter int unsigned CW        = 9
) (
    input  logic [BUF_BYTES-1:0][7:0] mem,
    output logic [CW-1:0]             len
);
    localparam logic [31:0] LIMIT = 32'(BUF_BYTES);

    logic [31:0] raw;

    always_comb begin
        raw = {mem[2], mem[3], mem[4], mem[5]};
        len = (raw > LIMIT) ? CW'(BUF_BYTES) : raw[CW-1:0];
    end
endmodule

// File: rtl/xfer_burst.sv
module xfer_burst #(
    parameter int unsigned BUF_BYTES = 256,
    parameter int unsigned CW        = 9
) (
    input  logic          davail,
    input  logic [CW-1:0] rsp_len,
    input  logic [CW-1:0] off,
    input  logic          narrow,
    output logic [15:0]   burst
);
    logic [CW-1:0] left;
    logic [15:0]   wide;

    always_comb begin
        left  = davail ? (rsp_len - off) : (CW'(BUF_BYTES) - off);
        wide  = 16'(left);
        burst = (narrow && wide > 16'd255) ? 16'd255 : wide;
    end
endmodule

// File: rtl/cmdrsp_xfer.sv
module cmdrsp_xfer
    import xfer_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 256,
    parameter logic [1:0]  FAMILY    = 2'b01,
    localparam int unsigned AW = $clog2(BUF_BYTES),
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          owner,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          reg_sel,
    input  logic [1:0]    byte_off,
    input  logic [2:0]    acc_size,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          go_pulse,
    output logic [CW-1:0] cmd_len,
    output logic          cancel_pulse,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [7:0]    eng_wdata,
    input  logic          eng_done,
    input  logic          eng_selftest,
    output logic          irq_ready,
    output logic          irq_valid
);
    localparam logic [CW-1:0] BUF_C = CW'(BUF_BYTES);

    typedef struct packed {
        xfer_state_e               st;
        logic [CW-1:0]             off;
        logic [CW-1:0]             clen;
        logic [7:0]                sts;
        logic                      abort_pend;
        logic [BUF_BYTES-1:0][7:0] mem;
    } regs_t;

    regs_t q, n;

    logic [CW-1:0] rsp_len;
    logic [15:0]   burst;
    logic [31:0]   wmask, wv, clen32;
    logic [2:0]    lim, eff;
    logic [7:0]    rbyte;
    logic          need_irq;

    xfer_len_parse #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_len (
        .mem (q.mem),
        .len (rsp_len)
    );

    xfer_burst #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_burst (
        .davail  (q.sts[B_DAVAIL]),
        .rsp_len (rsp_len),
        .off     (q.off),
        .narrow  (acc_size == 3'd1),
        .burst   (burst)
    );

    always_comb begin
        n            = q;
        rdata        = '1;
        go_pulse     = 1'b0;
        cancel_pulse = 1'b0;
        irq_ready    = 1'b0;
        irq_valid    = 1'b0;
        rbyte        = 8'hFF;
        need_irq     = 1'b0;
        clen32       = '0;

        lim = 3'd4 - {1'b0, byte_off};
        eff = (acc_size > lim) ? lim : acc_size;
        case (acc_size)
            3'd1:    wmask = 32'h0000_00FF;
            3'd2:    wmask = 32'h0000_FFFF;
            default: wmask = 32'hFFFF_FFFF;
        endcase
        wv = (wdata & wmask) << {byte_off, 3'b000};

        // engine side
        if (q.st == XS_EXEC) begin
            if (eng_we) n.mem[eng_addr] = eng_wdata;
            if (eng_done) begin
                if (eng_selftest) n.sts = n.sts | F_STDONE;
                n.off = '0;
                if (q.abort_pend) begin
                    n.st         = XS_READY;
                    n.sts        = sts_keep(n.sts, F_CRDY);
                    n.abort_pend = 1'b0;
                    irq_ready    = 1'b1;
                end else begin
                    n.st      = XS_DONE;
                    n.sts     = sts_keep(n.sts, F_VALID | F_DAVAIL);
                    irq_valid = 1'b1;
                end
            end
        end

        // host side
        if (owner && wr_en && !reg_sel) begin
            case ({wv[B_CRDY], wv[B_GO], wv[B_RETRY]})
                3'b100: begin
                    case (q.st)
                        XS_IDLE: begin
                            n.st      = XS_READY;
                            n.sts     = sts_keep(n.sts, F_CRDY);
                            irq_ready = 1'b1;
                        end
                        XS_READY: n.off = '0;
                        XS_RECV: begin
                            n.st      = XS_READY;
                            n.off     = '0;
                            n.sts     = sts_keep(n.sts, F_CRDY);
                            irq_ready = 1'b1;
                        end
                        XS_EXEC: begin
                            n.abort_pend = 1'b1;
                            cancel_pulse = 1'b1;
                        end
                        XS_DONE: begin
                            n.st  = XS_READY;
                            n.off = '0;
                            if (!q.sts[B_CRDY]) begin
                                n.sts     = sts_keep(n.sts, F_CRDY);
                                irq_ready = 1'b1;
                            end
                            n.sts[B_DAVAIL] = 1'b0;
                        end
                        default: ;
                    endcase
                end
                3'b010: begin
                    if (q.st == XS_RECV && !q.sts[B_EXPECT]) begin
                        n.st     = XS_EXEC;
                        n.clen   = q.off;
                        go_pulse = 1'b1;
                    end
                end
                3'b001: begin
                    if (q.st == XS_DONE) begin
                        n.off = '0;
                        n.sts = sts_keep(n.sts, F_VALID | F_DAVAIL);
                    end
                end
                default: ;
            endcase
        end else if (owner && wr_en && reg_sel) begin
            if (q.st == XS_READY || q.st == XS_RECV) begin
                if (q.st == XS_READY) begin
                    n.st  = XS_RECV;
                    n.sts = sts_keep(n.sts, F_EXPECT | F_VALID);
                end
                for (int k = 0; k < 4; k++) begin
                    if (3'(k) < eff && n.sts[B_EXPECT]) begin
                        if (n.off < BUF_C) begin
                            n.mem[n.off[AW-1:0]] = wdata[8*k +: 8];
                            n.off = n.off + 1'b1;
                        end else begin
                            n.sts = sts_keep(n.sts, F_VALID);
                        end
                    end
                end
                if (n.off > CW'(5) && n.sts[B_EXPECT]) begin
                    need_irq = !n.sts[B_VALID];
                    clen32   = {n.mem[2], n.mem[3], n.mem[4], n.mem[5]};
                    if (clen32 > 32'(n.off)) n.sts = sts_keep(n.sts, F_EXPECT | F_VALID);
                    else                     n.sts = sts_keep(n.sts, F_VALID);
                    if (need_irq) irq_valid = 1'b1;
                end
            end
        end else if (owner && rd_en && !reg_sel) begin
            rdata = {4'b0, FAMILY, 2'b0, burst, q.sts} >> {byte_off, 3'b000};
        end else if (owner && rd_en && reg_sel) begin
            rdata = '0;
            for (int k = 0; k < 4; k++) begin
                if (3'(k) < eff) begin
                    if (q.st == XS_DONE && n.sts[B_DAVAIL]) begin
                        rbyte = n.mem[n.off[AW-1:0]];
                        n.off = n.off + 1'b1;
                        if (n.off >= rsp_len) begin
                            n.sts     = sts_keep(n.sts, F_VALID);
                            irq_valid = 1'b1;
                        end
                    end else begin
                        rbyte = 8'hFF;
                    end
                    rdata[8*k +: 8] = rbyte;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign cmd_len = q.clen;

endmodule

// File: rtl/xfer_chk.sv
module xfer_chk
    import xfer_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 256,
    parameter int unsigned CW        = 9
) (
    input logic          clk,
    input logic          rst_n,
    input xfer_state_e   st,
    input logic [7:0]    sts,
    input logic [CW-1:0] off,
    input logic          abort_pend,
    input logic          go_pulse,
    input logic          irq_ready,
    input logic          eng_done
);
    AST_GO_ENTERS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> st == XS_EXEC); // R3

    AST_DONE_TO_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && st == XS_EXEC && !abort_pend)
        |=> (st == XS_DONE && sts[B_VALID] && sts[B_DAVAIL] && off == '0)); // R7

    AST_ABORT_EXEC_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && st == XS_EXEC && abort_pend) |=> (st == XS_READY && sts[B_CRDY])); // R13

    AST_READY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ready |=> st == XS_READY); // R2

    AST_STDONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sts[B_STDONE] |=> sts[B_STDONE]); // R10

    AST_OFF_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        off <= CW'(BUF_BYTES)); // R6

    AST_DAVAIL_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st != XS_DONE |-> !sts[B_DAVAIL]); // R8
endmodule

bind cmdrsp_xfer xfer_chk #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (q.st),
    .sts        (q.sts),
    .off        (q.off),
    .abort_pend (q.abort_pend),
    .go_pulse   (go_pulse),
    .irq_ready  (irq_ready),
    .eng_done   (eng_done)
);

// File: tb/tb_cmdrsp_xfer.sv
module tb_cmdrsp_xfer;
    localparam int BUF = 256;
    localparam int CW  = 9;

    logic clk = 0, rst_n = 0;
    logic owner = 1, wr_en = 0, rd_en = 0, reg_sel = 0;
    logic [1:0] byte_off = 0;
    logic [2:0] acc_size = 4;
    logic [31:0] wdata = 0, rdata;
    logic go_pulse, cancel_pulse, irq_ready, irq_valid;
    logic [CW-1:0] cmd_len;
    logic eng_we = 0, eng_done = 0, eng_selftest = 0;
    logic [7:0] eng_addr = 0, eng_wdata = 0;

    always #5 clk = ~clk;

    cmdrsp_xfer #(.BUF_BYTES(BUF), .FAMILY(2'b01)) dut (
        .clk(clk), .rst_n(rst_n), .owner(owner), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .byte_off(byte_off), .acc_size(acc_size), .wdata(wdata),
        .rdata(rdata), .go_pulse(go_pulse), .cmd_len(cmd_len), .cancel_pulse(cancel_pulse),
        .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done),
        .eng_selftest(eng_selftest), .irq_ready(irq_ready), .irq_valid(irq_valid));

    // behavioural reference: 0 idle, 1 ready, 2 reception, 3 execution, 4 completion
    int         m_st = 0, m_off = 0, m_clen = 0, m_clen_vis = 0;
    bit [7:0]   m_sts = 0;
    bit         m_abort = 0;
    logic [7:0] m_buf [BUF];

    bit e_go, e_cancel, e_irdy, e_ival, e_rd;
    logic [31:0] e_rdata;
    string e_tag;
    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] supd(bit [7:0] f);
        return (m_sts & 8'h04) | f;
    endfunction

    function automatic int rsp_len();
        logic [31:0] r = {m_buf[2], m_buf[3], m_buf[4], m_buf[5]};
        if (r > 32'(BUF)) return BUF;
        return int'(r);
    endfunction

    function automatic int effsz(int off, int sz);
        return (sz > 4 - off) ? 4 - off : sz;
    endfunction

    function automatic logic [31:0] m_status_read(int off, int sz);
        int b = m_sts[4] ? rsp_len() - m_off : BUF - m_off;
        logic [31:0] v;
        if (sz == 1 && b > 255) b = 255;
        v = (32'd1 << 26) | (32'(b) << 8) | 32'(m_sts);
        return v >> (8 * off);
    endfunction

    function automatic logic [31:0] m_data_read(int off, int sz);
        logic [31:0] r = 0;
        logic [7:0] b;
        for (int k = 0; k < effsz(off, sz); k++) begin
            if (m_st == 4 && m_sts[4]) begin
                b = m_buf[m_off];
                m_off++;
                if (m_off >= rsp_len()) begin m_sts = supd(8'h80); e_ival = 1; end
            end else b = 8'hFF;
            r = r | (32'(b) << (8 * k));
        end
        return r;
    endfunction

    function automatic void m_status_write(int off, int sz, logic [31:0] d);
        logic [31:0] mk = (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        logic [31:0] v = (d & mk) << (8 * off);
        if (v[6] && !v[5] && !v[1]) begin
            case (m_st)
                0: begin m_sts = supd(8'h40); m_st = 1; e_irdy = 1; end
                1: m_off = 0;
                2: begin m_off = 0; m_st = 1; m_sts = supd(8'h40); e_irdy = 1; end
                3: begin m_abort = 1; e_cancel = 1; end
                4: begin
                    m_off = 0; m_st = 1;
                    if (!m_sts[6]) begin m_sts = supd(8'h40); e_irdy = 1; end
                    m_sts[4] = 0;
                end
                default: ;
            endcase
        end else if (!v[6] && v[5] && !v[1]) begin
            if (m_st == 2 && !m_sts[3]) begin m_st = 3; e_go = 1; m_clen = m_off; end
        end else if (!v[6] && !v[5] && v[1]) begin
            if (m_st == 4) begin m_off = 0; m_sts = supd(8'h90); end
        end
    endfunction

    function automatic void m_data_write(int off, int sz, logic [31:0] d);
        logic [31:0] len;
        bit need;
        if (m_st != 1 && m_st != 2) return;
        if (m_st == 1) begin m_st = 2; m_sts = supd(8'h88); end
        for (int k = 0; k < effsz(off, sz); k++) begin
            if (m_sts[3]) begin
                if (m_off < BUF) begin m_buf[m_off] = d[8*k +: 8]; m_off++; end
                else m_sts = supd(8'h80);
            end
        end
        if (m_off > 5 && m_sts[3]) begin
            need = !m_sts[7];
            len = {m_buf[2], m_buf[3], m_buf[4], m_buf[5]};
            m_sts = (len > 32'(m_off)) ? supd(8'h88) : supd(8'h80);
            if (need) e_ival = 1;
        end
    endfunction

    task automatic cyc();
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; eng_we = 0; eng_done = 0; eng_selftest = 0; owner = 1;
        e_go = 0; e_cancel = 0; e_irdy = 0; e_ival = 0; e_rd = 0;
    endtask

    task automatic wr(bit sel, int off, int sz, logic [31:0] d, bit own = 1);
        cyc();
        wr_en = 1; reg_sel = sel; byte_off = 2'(off); acc_size = 3'(sz); wdata = d; owner = own;
        if (own) begin
            if (sel) m_data_write(off, sz, d); else m_status_write(off, sz, d);
        end
    endtask

    task automatic rd(bit sel, int off, int sz, string tag, bit own = 1);
        cyc();
        rd_en = 1; reg_sel = sel; byte_off = 2'(off); acc_size = 3'(sz); owner = own;
        e_rd = 1; e_tag = tag;
        if (!own) e_rdata = 32'hFFFF_FFFF;
        else if (sel) e_rdata = m_data_read(off, sz);
        else e_rdata = m_status_read(off, sz);
    endtask

    task automatic eng_byte(int a, logic [7:0] d);
        cyc();
        eng_we = 1; eng_addr = 8'(a); eng_wdata = d;
        if (m_st == 3) m_buf[a] = d;
    endtask

    task automatic eng_fin(bit st);
        cyc();
        eng_done = 1; eng_selftest = st;
        if (m_st == 3) begin
            if (st) m_sts = m_sts | 8'h04;
            m_off = 0;
            if (m_abort) begin m_st = 1; m_sts = supd(8'h40); e_irdy = 1; m_abort = 0; end
            else begin m_st = 4; m_sts = supd(8'h90); e_ival = 1; end
        end
    endtask

    always @(posedge clk) m_clen_vis <= m_clen;

    always @(negedge clk) if (rst_n && !done_flag) begin
        chk(go_pulse == e_go, "R3 go_pulse", 32'(go_pulse), 32'(e_go));
        chk(cancel_pulse == e_cancel, "R13 cancel_pulse", 32'(cancel_pulse), 32'(e_cancel));
        chk(irq_ready == e_irdy, "R2 irq_ready", 32'(irq_ready), 32'(e_irdy));
        chk(irq_valid == e_ival, "R7/R8 irq_valid", 32'(irq_valid), 32'(e_ival));
        chk(32'(cmd_len) == 32'(m_clen_vis), "R3 cmd_len", 32'(cmd_len), 32'(m_clen_vis));
        if (e_rd) chk(rdata === e_rdata, e_tag, rdata, e_rdata);
    end

    task automatic finish_up();
        if (done_flag) return;
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_up();
    end

    initial begin
        for (int i = 0; i < BUF; i++) m_buf[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        rd(0, 0, 4, "R1 status after reset");
        rd(0, 1, 1, "R9 narrow burst saturates");
        rd(1, 0, 4, "R8 data read in idle");
        wr(1, 0, 4, 32'h1234_5678);                 // R5 dropped in idle
        rd(0, 0, 4, "R5 idle write dropped");
        wr(0, 0, 1, 32'h40, 0);                     // R12 non-owner command-ready
        rd(0, 0, 4, "R12 still idle");
        rd(0, 0, 4, "R12 non-owner read", 0);
        wr(0, 0, 1, 32'h20);                        // R3 go in idle ignored
        wr(0, 0, 1, 32'h40);                        // R2 idle -> ready
        rd(0, 0, 4, "R2 ready flags");
        wr(0, 0, 1, 32'h40);                        // R2 ready: rewind only
        // command of 12 bytes: 80 01 00 00 00 0C AA BB CC DD EE FF
        wr(1, 0, 4, 32'h0000_0180);                 // R5 ready -> reception
        rd(0, 0, 4, "R5 reception flags");
        wr(1, 0, 4, 32'hBBAA_0C00);
        rd(0, 0, 4, "R6 expect held");
        wr(0, 0, 1, 32'h20);                        // R3 go ignored while expecting
        wr(1, 2, 4, 32'h1111_DDCC);                 // R11 clipped to two bytes
        rd(0, 0, 4, "R11 clipped count");
        wr(1, 0, 1, 32'h0000_00EE);
        wr(1, 0, 1, 32'h0000_00FF);
        rd(0, 0, 4, "R6 expect cleared");
        wr(0, 0, 1, 32'h60);                        // two command bits: ignored
        wr(0, 0, 1, 32'h20);                        // R3 go honoured
        wr(1, 0, 4, 32'hDEAD_BEEF);                 // R5 dropped in execution
        rd(1, 0, 4, "R8 read in execution");
        // response: C4 00 00 00 00 0A 11 22 33 44
        eng_byte(0, 8'hC4); eng_byte(1, 8'h00); eng_byte(2, 8'h00); eng_byte(3, 8'h00);
        eng_byte(4, 8'h00); eng_byte(5, 8'h0A); eng_byte(6, 8'h11); eng_byte(7, 8'h22);
        eng_byte(8, 8'h33); eng_byte(9, 8'h44);
        eng_fin(1);                                 // R7
        rd(0, 0, 4, "R7 completion flags R9 burst");
        wr(1, 0, 4, 32'h5555_5555);                 // R5 dropped in completion
        rd(1, 0, 4, "R8 first word");
        rd(1, 3, 4, "R11 clipped read");
        rd(0, 0, 4, "R9 remaining");
        rd(1, 0, 4, "R8 third word");
        rd(1, 0, 2, "R8 last bytes");
        rd(1, 0, 4, "R8 past end");
        rd(0, 0, 4, "R8 davail cleared");
        wr(0, 0, 1, 32'h02);                        // R4 retry
        rd(0, 0, 4, "R4 retry flags");
        rd(1, 0, 4, "R4 reread first word");
        wr(0, 0, 1, 32'h40);                        // R2 completion -> ready
        rd(0, 0, 4, "R10 self-test kept");
        // abort in reception
        wr(1, 0, 4, 32'h0000_0180);
        wr(0, 0, 1, 32'h40);                        // R2 abort reception
        rd(0, 0, 4, "R2 after reception abort");
        // abort in execution, command of 6 bytes
        wr(1, 0, 4, 32'h0000_0180);
        wr(1, 0, 2, 32'h0000_0600);
        rd(0, 0, 4, "R6 six-byte command complete");
        wr(0, 0, 1, 32'h20);
        wr(0, 0, 1, 32'h40);                        // R13 cancel
        rd(0, 0, 4, "R13 still executing");
        eng_fin(0);                                 // R13 abort completes
        rd(0, 0, 4, "R13 ready after abort R10");
        wr(0, 0, 1, 32'h02);                        // R4 retry outside completion ignored
        rd(0, 0, 4, "R4 retry ignored");
        // buffer full: length 0x1000
        wr(1, 0, 4, 32'h0000_0180);
        wr(1, 0, 4, 32'h0000_0010);
        for (int i = 2; i < BUF / 4; i++) wr(1, 0, 4, 32'(i));
        rd(0, 0, 4, "R6 full buffer still expecting");
        wr(1, 0, 4, 32'h7777_7777);                 // R6 buffer full clears expect
        rd(0, 0, 4, "R6 full buffer expect cleared");
        wr(0, 0, 1, 32'h40);
        rd(0, 0, 4, "R2 ready after full abort");
        cyc();
        @(negedge clk);
        finish_up();
    end
endmodule